// File: doc/BRIEF.md
# Serial Anomaly Scoring Pipeline

This block receives a 64-bit packet one bit per clock, least-significant bit first, accepting a bit only on cycles where the bit-valid input is high. Once the 64th bit has arrived it pulls two signed 8-bit features out of the packet. The first is a speed value in packet bits 31:24 and the second is a direction value in bits 23:16. It forms a fixed weighted sum of the two features and clamps negative sums to zero. It then grades the result into one of four 8-bit threat codes.

Completion is signalled by a single-cycle done pulse. The grade is valid on the score output in that same cycle and stays there until the next packet has been graded. When the grade is the top level, a single-cycle interrupt pulse comes out alongside done. Capture, feature latch, arithmetic and grading are separate register stages. A new packet can therefore start on the cycle right after the previous packet's last bit.

Top module: `anomaly_scorer`

## Requirements
- R1: A bit on `serialIn` is taken only on a rising clock edge where `bitValid` is 1. Bits arrive least-significant first. Cycles with `bitValid` at 0 neither shift nor count, whatever `serialIn` does. Every 64th accepted bit completes a packet, and the next accepted bit starts a new one.
- R2: The speed feature is packet bits 31:24 and the direction feature is packet bits 23:16, both two's complement 8-bit. No other packet bit affects the result.
- R3: The raw sum is 12 × speed + 88 × direction, computed signed without overflow for every pair of inputs from −128 to 127.
- R4: A raw sum below zero is treated as zero before grading.
- R5: Grading of the clamped sum S: S < 1024 gives 8'h00, 1024 ≤ S < 2048 gives 8'h55, 2048 ≤ S < 4096 gives 8'hAA, and S ≥ 4096 gives 8'hFF.
- R6: `doneOut` is high for exactly one cycle per packet. That cycle follows the third rising edge after the edge that accepts the packet's last bit. `scoreOut` carries that packet's grade in the same cycle.
- R7: `irqOut` is high only in a `doneOut` cycle, and it is high in every `doneOut` cycle whose grade is 8'hFF.
- R8: `scoreOut` changes only in a `doneOut` cycle and otherwise holds the last grade.
- R9: While `rstN` is low, `scoreOut` is 8'h00 and `doneOut` and `irqOut` are 0. Any partly received packet is discarded, so the next accepted bit is bit 0 of a new packet.
- R10: Packets sent back to back, with no idle cycle between them, are each graded and each produce their own done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial packet data, LSB first |
| bitValid | input | 1 | High when `serialIn` carries a packet bit |
| scoreOut | output | 8 | Threat grade of the last packet |
| doneOut | output | 1 | One-cycle pulse when a new grade is on `scoreOut` |
| irqOut | output | 1 | One-cycle pulse with `doneOut` for the top grade |

## Verification
The bench places clamped sums exactly on each grading edge and one step below it: 1020/1024, 2036/2048 and 4084/4096. An off-by-one comparison or a swapped level would grade one of these pairs wrongly. It drives the extreme feature pairs, including a large positive speed against a most-negative direction. A design that treats the features as unsigned, or whose sum is too narrow, would grade those as critical instead of safe. It surrounds the two feature bytes with all-ones and alternating filler, and it stalls `bitValid` while `serialIn` keeps toggling. A wrong field slice or an ungated shift would then produce a different grade. It also resets halfway through a packet, which exposes a bit counter that keeps its stale count. Every done pulse is checked against the exact expected cycle, so an extra or missing pipeline register also shows up.

// File: rtl/anomaly_pkg.sv
package anomaly_pkg;

  // Strobes issued by the control unit to the datapath, one per stage.
  typedef struct packed {
    logic shiftEn;   // accept one serial bit into the capture window
    logic featLoad;  // latch both features from the completed window
    logic sumLoad;   // latch the clamped weighted sum
    logic outLoad;   // latch the grade and raise done
  } stage_strobe_t;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_SAFE     = 8'h00;
  localparam logic [CODE_W-1:0] CODE_CAUTION  = 8'h55;
  localparam logic [CODE_W-1:0] CODE_WARNING  = 8'hAA;
  localparam logic [CODE_W-1:0] CODE_CRITICAL = 8'hFF;

  // Number of grading thresholds (levels minus one).
  localparam int NUM_LIMITS = 3;

  // Register stages between last-bit acceptance and the done pulse.
  localparam int PIPE_DEPTH = 3;

endpackage

// File: rtl/anomaly_ctrl.sv
module anomaly_ctrl
  import anomaly_pkg::*;
#(
  parameter int PKT_BITS = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitValid,
  output stage_strobe_t strb
);

  localparam int CNT_W = $clog2(PKT_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_BITS - 1);

  logic [CNT_W-1:0]      bitCnt;
  logic                  lastBit;
  logic [PIPE_DEPTH-1:0] stageVld;

  assign lastBit = bitValid && (bitCnt == LAST_IDX);

  // Position of the next accepted bit inside the packet.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (bitValid) begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  // Token marching through the stages behind a completed packet.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageVld <= '0;
    end else begin
      stageVld <= {stageVld[PIPE_DEPTH-2:0], lastBit};
    end
  end

  always_comb begin
    strb.shiftEn  = bitValid;
    strb.featLoad = stageVld[0];
    strb.sumLoad  = stageVld[1];
    strb.outLoad  = stageVld[2];
  end

endmodule

// File: rtl/anomaly_mac.sv
module anomaly_mac #(
  parameter int FEAT_W = 8,
  parameter int W_VEL  = 12,
  parameter int W_HEAD = 88,
  parameter int ACC_W  = 16
) (
  input  logic signed [FEAT_W-1:0] velIn,
  input  logic signed [FEAT_W-1:0] headIn,
  output logic        [ACC_W-2:0]  reluSum
);

  localparam int EXT_W = ACC_W - FEAT_W;
  localparam logic signed [ACC_W-1:0] K_VEL  = ACC_W'(W_VEL);
  localparam logic signed [ACC_W-1:0] K_HEAD = ACC_W'(W_HEAD);

  logic signed [ACC_W-1:0] velX;
  logic signed [ACC_W-1:0] headX;
  logic signed [ACC_W-1:0] termVel;
  logic signed [ACC_W-1:0] termHead;
  logic signed [ACC_W-1:0] rawSum;

  always_comb begin
    velX     = {{EXT_W{velIn[FEAT_W-1]}}, velIn};
    headX    = {{EXT_W{headIn[FEAT_W-1]}}, headIn};
    termVel  = velX * K_VEL;
    termHead = headX * K_HEAD;
    rawSum   = termVel + termHead;
    // Rectifier: a negative sum becomes zero, the sign bit is then redundant.
    reluSum  = rawSum[ACC_W-1] ? '0 : rawSum[ACC_W-2:0];
  end

endmodule

// File: rtl/anomaly_grade.sv
module anomaly_grade
  import anomaly_pkg::*;
#(
  parameter int MAG_W        = 15,
  parameter int THR_CAUTION  = 1024,
  parameter int THR_WARNING  = 2048,
  parameter int THR_CRITICAL = 4096
) (
  input  logic [MAG_W-1:0]  magIn,
  output logic [CODE_W-1:0] codeOut,
  output logic              critical
);

  // Limits in ascending order; the highest one passed decides the grade.
  localparam logic [MAG_W-1:0] LIMIT [NUM_LIMITS] = '{
    MAG_W'(THR_CAUTION), MAG_W'(THR_WARNING), MAG_W'(THR_CRITICAL)
  };

  logic [NUM_LIMITS-1:0] atOrAbove;

  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_cmp
    assign atOrAbove[g] = (magIn >= LIMIT[g]);
  end

  always_comb begin
    if (atOrAbove[2])      codeOut = CODE_CRITICAL;
    else if (atOrAbove[1]) codeOut = CODE_WARNING;
    else if (atOrAbove[0]) codeOut = CODE_CAUTION;
    else                   codeOut = CODE_SAFE;
    critical = atOrAbove[2];
  end

endmodule

// File: rtl/anomaly_dp.sv
module anomaly_dp
  import anomaly_pkg::*;
#(
  parameter int PKT_BITS     = 64,
  parameter int FEAT_W       = 8,
  parameter int VEL_LSB      = 24,
  parameter int HEAD_LSB     = 16,
  parameter int W_VEL        = 12,
  parameter int W_HEAD       = 88,
  parameter int ACC_W        = 16,
  parameter int THR_CAUTION  = 1024,
  parameter int THR_WARNING  = 2048,
  parameter int THR_CRITICAL = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  stage_strobe_t     strb,
  output logic [CODE_W-1:0] scoreOut,
  output logic              doneOut,
  output logic              irqOut
);

  // Bits below the lower feature are never needed, so the capture window
  // only spans from that feature up to the packet's top bit.
  localparam int WIN_LSB  = (HEAD_LSB < VEL_LSB) ? HEAD_LSB : VEL_LSB;
  localparam int WIN_W    = PKT_BITS - WIN_LSB;
  localparam int VEL_POS  = VEL_LSB - WIN_LSB;
  localparam int HEAD_POS = HEAD_LSB - WIN_LSB;
  localparam int MAG_W    = ACC_W - 1;

  logic [WIN_W-1:0]         window;
  logic signed [FEAT_W-1:0] velReg;
  logic signed [FEAT_W-1:0] headReg;
  logic [MAG_W-1:0]         reluSum;
  logic [MAG_W-1:0]         sumReg;
  logic [CODE_W-1:0]        gradeCode;
  logic                     gradeCrit;

  // Stage 0: serial capture, new bits enter at the top and move down.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window <= '0;
    end else if (strb.shiftEn) begin
      window <= {serialIn, window[WIN_W-1:1]};
    end
  end

  // Stage 1: feature latch, frees the window for the next packet.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      velReg  <= '0;
      headReg <= '0;
    end else if (strb.featLoad) begin
      velReg  <= window[VEL_POS +: FEAT_W];
      headReg <= window[HEAD_POS +: FEAT_W];
    end
  end

  anomaly_mac #(
    .FEAT_W (FEAT_W),
    .W_VEL  (W_VEL),
    .W_HEAD (W_HEAD),
    .ACC_W  (ACC_W)
  ) u_mac (
    .velIn   (velReg),
    .headIn  (headReg),
    .reluSum (reluSum)
  );

  // Stage 2: clamped weighted sum.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
    end else if (strb.sumLoad) begin
      sumReg <= reluSum;
    end
  end

  anomaly_grade #(
    .MAG_W        (MAG_W),
    .THR_CAUTION  (THR_CAUTION),
    .THR_WARNING  (THR_WARNING),
    .THR_CRITICAL (THR_CRITICAL)
  ) u_grade (
    .magIn    (sumReg),
    .codeOut  (gradeCode),
    .critical (gradeCrit)
  );

  // Stage 3: grade, done and interrupt leave the block from flops.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scoreOut <= CODE_SAFE;
      doneOut  <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      doneOut <= strb.outLoad;
      irqOut  <= strb.outLoad && gradeCrit;
      if (strb.outLoad) begin
        scoreOut <= gradeCode;
      end
    end
  end

endmodule

// File: rtl/anomaly_scorer.sv
module anomaly_scorer
  import anomaly_pkg::*;
#(
  parameter int PKT_BITS     = 64,
  parameter int FEAT_W       = 8,
  parameter int VEL_LSB      = 24,
  parameter int HEAD_LSB     = 16,
  parameter int W_VEL        = 12,
  parameter int W_HEAD       = 88,
  parameter int ACC_W        = 16,
  parameter int THR_CAUTION  = 1024,
  parameter int THR_WARNING  = 2048,
  parameter int THR_CRITICAL = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  logic       bitValid,
  output logic [7:0] scoreOut,
  output logic       doneOut,
  output logic       irqOut
);

  stage_strobe_t strb;

  anomaly_ctrl #(
    .PKT_BITS (PKT_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .strb     (strb)
  );

  anomaly_dp #(
    .PKT_BITS     (PKT_BITS),
    .FEAT_W       (FEAT_W),
    .VEL_LSB      (VEL_LSB),
    .HEAD_LSB     (HEAD_LSB),
    .W_VEL        (W_VEL),
    .W_HEAD       (W_HEAD),
    .ACC_W        (ACC_W),
    .THR_CAUTION  (THR_CAUTION),
    .THR_WARNING  (THR_WARNING),
    .THR_CRITICAL (THR_CRITICAL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .strb     (strb),
    .scoreOut (scoreOut),
    .doneOut  (doneOut),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/anomaly_chk.sv
module anomaly_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] scoreOut,
  input logic       doneOut,
  input logic       irqOut
);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  a_r7_irq_only_with_done: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> doneOut);

  a_r7_irq_matches_top: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (irqOut == (scoreOut == 8'hFF)));

  a_r8_score_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(scoreOut) |-> doneOut);

  a_r5_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    (scoreOut == 8'h00) || (scoreOut == 8'h55) ||
    (scoreOut == 8'hAA) || (scoreOut == 8'hFF));

  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> (scoreOut == 8'h00) && !doneOut && !irqOut);

endmodule

bind anomaly_scorer anomaly_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .scoreOut (scoreOut),
  .doneOut  (doneOut),
  .irqOut   (irqOut)
);

// File: tb/sim_anomaly_scorer.sv
`timescale 1ns/1ps
module sim_anomaly_scorer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       serialIn;
  logic       bitValid;
  logic [7:0] scoreOut;
  logic       doneOut;
  logic       irqOut;

  always #2 clk = ~clk;   // 250 MHz

  anomaly_scorer u0 (
    .clk      (clk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .bitValid (bitValid),
    .scoreOut (scoreOut),
    .doneOut  (doneOut),
    .irqOut   (irqOut)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seen = 0;
  int pushed = 0;
  bit finished = 1'b0;

  logic [7:0] codeQ[$];
  int         atQ[$];
  string      tagQ[$];

  always @(posedge clk) cyc++;

  // Grading model taken from R3, R4 and R5.
  function automatic logic [7:0] expCode(int v, int h);
    int s;
    s = 12 * v + 88 * h;
    if (s < 0) s = 0;
    if (s >= 4096) return 8'hFF;
    if (s >= 2048) return 8'hAA;
    if (s >= 1024) return 8'h55;
    return 8'h00;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Driver: shifts one packet out LSB first, queues its expected grade.
  task automatic sendPacket(int v, int h, logic [31:0] hiFill,
                            logic [15:0] loFill, int gapEvery, string tag);
    logic [63:0] pkt;
    pkt = {hiFill, 8'(v), 8'(h), loFill};
    for (int i = 0; i < 64; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) begin
        bitValid = 1'b0;
        repeat (2) begin
          serialIn = ~serialIn;
          @(posedge clk); #1;
        end
      end
      bitValid = 1'b1;
      serialIn = pkt[i];
      @(posedge clk); #1;
    end
    bitValid = 1'b0;
    serialIn = 1'b0;
    // The edge that took the last bit has just passed: done is due 3 edges on (R6).
    codeQ.push_back(expCode(v, h));
    atQ.push_back(cyc + 3);
    tagQ.push_back(tag);
    pushed++;
  endtask

  task automatic drain();
    while (codeQ.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    bitValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      serialIn = ~serialIn;
      @(posedge clk); #1;
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse.
  logic [7:0] lastScore = 8'h00;
  logic       prevDone = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      lastScore = scoreOut;
      prevDone  = 1'b0;
    end else begin
      if (irqOut && !doneOut)
        check(1'b0, "R7 irq without done", irqOut, 0);
      if (doneOut && prevDone)
        check(1'b0, "R6 done longer than one cycle", 1, 0);
      if (doneOut) begin
        seen++;
        if (codeQ.size() == 0) begin
          check(1'b0, "R6 done with no packet pending", 1, 0);
        end else begin
          logic [7:0] c;
          int at;
          string t;
          c = codeQ.pop_front();
          at = atQ.pop_front();
          t = tagQ.pop_front();
          check(scoreOut == c, {t, " grade"}, scoreOut, c);
          check(cyc == at, {"R6 done cycle for ", t}, cyc, at);
          check(irqOut == (c == 8'hFF), {"R7 irq for ", t}, irqOut, (c == 8'hFF));
        end
        lastScore = scoreOut;
      end else if (scoreOut != lastScore) begin
        check(1'b0, "R8 score changed without done", scoreOut, lastScore);
        lastScore = scoreOut;
      end
      prevDone = doneOut;
    end
  end

  initial begin
    rstN = 1'b1;
    bitValid = 1'b0;
    serialIn = 1'b0;
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(scoreOut == 8'h00, "R9 reset score", scoreOut, 0);
    check(doneOut == 1'b0 && irqOut == 1'b0, "R9 reset done/irq", {doneOut, irqOut}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    sendPacket(10, 5, 32'h0, 16'h0, 0, "R5 safe 560");
    sendPacket(120, 40, 32'h0, 16'h0, 0, "R7 critical 4960");
    drain();
    idle(20);
    check(scoreOut == 8'hFF, "R8/R1 grade held over idle toggling", scoreOut, 8'hFF);

    sendPacket(85, 0, 32'h0, 16'h0, 0, "R5 just below 1024");
    sendPacket(12, 10, 32'h0, 16'h0, 0, "R5 exactly 1024");
    sendPacket(23, 20, 32'h0, 16'h0, 0, "R5 below 2048");
    sendPacket(24, 20, 32'h0, 16'h0, 0, "R5 exactly 2048");
    sendPacket(47, 40, 32'h0, 16'h0, 0, "R5 below 4096");
    sendPacket(48, 40, 32'h0, 16'h0, 0, "R5 exactly 4096");
    sendPacket(-100, 0, 32'h0, 16'h0, 0, "R4 negative sum clamps");
    sendPacket(127, 127, 32'h0, 16'h0, 0, "R3 max pair");
    sendPacket(-128, -128, 32'h0, 16'h0, 0, "R3 min pair");
    sendPacket(-128, 127, 32'h0, 16'h0, 0, "R3 mixed 9640");
    sendPacket(127, -128, 32'h0, 16'h0, 0, "R3 signed heading dominates");
    sendPacket(24, 20, 32'hFFFF_FFFF, 16'hFFFF, 0, "R2 ones filler");
    sendPacket(12, 10, 32'hAAAA_5555, 16'h5AA5, 0, "R2 mixed filler");
    sendPacket(-1, 60, 32'h8000_0001, 16'h8001, 0, "R2 edge filler");
    drain();
    check(seen == pushed, "R10 one done per back-to-back packet", seen, pushed);

    sendPacket(48, 40, 32'h1234_5678, 16'h9ABC, 5, "R1 stalled valid");
    sendPacket(120, 40, 32'h0, 16'h0, 0, "R1 critical before reset");
    drain();

    // R9: abandon a packet half way through.
    bitValid = 1'b1;
    for (int i = 0; i < 30; i++) begin
      serialIn = i[0];
      @(posedge clk); #1;
    end
    bitValid = 1'b0;
    rstN = 1'b0;
    #1;
    check(scoreOut == 8'h00, "R9 mid-packet reset clears score", scoreOut, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;
    sendPacket(24, 20, 32'h0, 16'h0, 0, "R9 packet after reset");
    drain();
    idle(10);
    check(seen == pushed, "R6 no extra done pulses", seen, pushed);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", seen, pushed);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule